// File: doc/BRIEF.md
# Strobe-Pin Function Selector

This block decides, one bus cycle at a time, what two shared pins do: the address-latch strobe pin and the program-store strobe pin. Each pin either carries the waveform made by the bus sequencer or serves as a general-purpose port bit driven from the port-4 output latch. The block holds a port-options register, which also carries the port-0 pull-up enable and the port-3 high-drive enables for the pad ring, and an auxiliary register with a single strobe-off bit. The strobe-off bit silences the address-latch strobe while code runs from on-chip memory and lets it return by itself during any external access.

The bus sequencer raises `cycleLast` in the final clock of each bus cycle and presents `extNext`, the kind of the bus cycle that follows. Register writes land in shadow copies first. The shadow copies and the access kind are taken over at that boundary, so a strobe pulse is never cut short by a write or a mode change.

Top module: `alepsen_pin_ctrl`

## Requirements
- R1: After reset both pins are in strobe mode with strobe-off clear; the address-latch pin follows `aleWave`, the program-store pin is held at 1 (no external cycle yet), both enables are 1, and `p0PullUp` and `p3HighDrive` are 0.
- R2: When the address-latch pin is in strobe mode and strobe-off is clear, `aleOut` equals `aleWave` and `aleOe` is 1 for internal and external cycles alike.
- R3: Strobe-off is auxiliary bit 0. When it is set and the pin is in strobe mode, an internal cycle holds `aleOut` at 1 with `aleOe` at 1.
- R4: With strobe-off set, an external cycle makes `aleOut` follow `aleWave` again. The strobe stops at the next internal cycle.
- R5: Port-options bit 6 puts the address-latch pin in port mode, and bit 7 does the same for the program-store pin. In port mode the pin output equals its latch bit (`p4Latch5` or `p4Latch6`) and the enable is the inverse of that bit.
- R6: In strobe mode the program-store pin is held at 1 during internal cycles and follows `psenWave` during external cycles, with `psenOe` at 1.
- R7: Port mode takes priority over strobe-off when both are set.
- R8: Port-options bit 0 drives `p0PullUp`. Bits 1 to 4 drive `p3HighDrive[0]` to `p3HighDrive[3]` (pins P3.4 to P3.7). Bit 5 has no effect.
- R9: `wrSel` 0 selects the port-options register and 1 selects the auxiliary register. Only auxiliary bit 0 is used. A write changes no output until the clock after the next `cycleLast`.
- R10: `extNext` is taken only in a clock where `cycleLast` is high, and it governs the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 port options, 1 auxiliary |
| wrData | input | 8 | Write data |
| cycleLast | input | 1 | Final clock of a bus cycle |
| extNext | input | 1 | Next cycle is external |
| aleWave | input | 1 | Address-latch waveform from the sequencer |
| psenWave | input | 1 | Program-store waveform (active low) |
| p4Latch5 | input | 1 | Port-4 latch bit 5 |
| p4Latch6 | input | 1 | Port-4 latch bit 6 |
| aleOut | output | 1 | Address-latch pin value |
| aleOe | output | 1 | Address-latch pin drive enable |
| psenOut | output | 1 | Program-store pin value |
| psenOe | output | 1 | Program-store pin drive enable |
| p0PullUp | output | 1 | Port-0 pull-up enable |
| p3HighDrive | output | 4 | High-drive enables for P3.4 to P3.7 |

## Verification
The bench builds the block with its default register width of 8 bits, which is fixed by the bit positions the neighbouring logic decodes. It therefore covers every mode combination of the two pins: strobe, suppressed and port, each under internal and external cycles. It also holds a write or an access-kind change across clocks with no boundary, which shows that a pin cannot switch function in the middle of a bus cycle.

// File: rtl/alepsen_pkg.sv
package alepsen_pkg;
  localparam int REG_W    = 8;
  localparam int HD_W     = 4;
  localparam int NUM_PINS = 2;
  localparam int PIN_ALE  = 0;
  localparam int PIN_PSEN = 1;
  localparam int AUX_OFF_BIT = 0;

  // port-options register layout
  typedef struct packed {
    logic            psenPort;  // bit 7
    logic            alePort;   // bit 6
    logic            rsvd;      // bit 5
    logic [HD_W-1:0] highDrive; // bits 4:1 -> P3.7..P3.4
    logic            pullUp;    // bit 0
  } optReg_t;

  // control to datapath strobes
  typedef struct packed {
    logic [NUM_PINS-1:0] portMode;
    logic [NUM_PINS-1:0] suppress;
  } pinCtrl_t;
endpackage

// File: rtl/alepsen_ctrl.sv
module alepsen_ctrl
  import alepsen_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrEn,
  input  logic            wrSel,
  input  logic [REG_W-1:0] wrData,
  input  logic            cycleLast,
  input  logic            extNext,
  output pinCtrl_t        ctrlStb,
  output logic            p0PullUp,
  output logic [HD_W-1:0] p3HighDrive
);
  optReg_t optShadow, optAct;
  logic    aleOffShadow, aleOffAct;
  logic    extAct;

  // shadow copies take writes at once; live copies only at a cycle boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      optShadow    <= '0;
      aleOffShadow <= 1'b0;
      optAct       <= '0;
      aleOffAct    <= 1'b0;
      extAct       <= 1'b0;
    end else begin
      if (wrEn && !wrSel) optShadow    <= optReg_t'(wrData);
      if (wrEn &&  wrSel) aleOffShadow <= wrData[AUX_OFF_BIT];
      if (cycleLast) begin
        optAct    <= optShadow;
        aleOffAct <= aleOffShadow;
        extAct    <= extNext;
      end
    end
  end

  always_comb begin
    ctrlStb                   = '0;
    ctrlStb.portMode[PIN_ALE]  = optAct.alePort;
    ctrlStb.portMode[PIN_PSEN] = optAct.psenPort;
    ctrlStb.suppress[PIN_ALE]  = aleOffAct & ~extAct;
    ctrlStb.suppress[PIN_PSEN] = ~extAct;
  end

  assign p0PullUp    = optAct.pullUp;
  assign p3HighDrive = optAct.highDrive;

  logic unusedRsvd;
  assign unusedRsvd = optAct.rsvd | optShadow.rsvd;
endmodule

// File: rtl/alepsen_pin_mux.sv
module alepsen_pin_mux (
  input  logic portMode,
  input  logic suppress,
  input  logic wave,
  input  logic latchBit,
  output logic pinOut,
  output logic pinOe
);
  always_comb begin
    if (portMode) begin
      pinOut = latchBit;
      pinOe  = ~latchBit;
    end else if (suppress) begin
      pinOut = 1'b1;
      pinOe  = 1'b1;
    end else begin
      pinOut = wave;
      pinOe  = 1'b1;
    end
  end
endmodule

// File: rtl/alepsen_dpath.sv
module alepsen_dpath
  import alepsen_pkg::*;
(
  input  pinCtrl_t            ctrlStb,
  input  logic [NUM_PINS-1:0] wave,
  input  logic [NUM_PINS-1:0] latchBits,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    alepsen_pin_mux u_mux (
      .portMode (ctrlStb.portMode[i]),
      .suppress (ctrlStb.suppress[i]),
      .wave     (wave[i]),
      .latchBit (latchBits[i]),
      .pinOut   (pinOut[i]),
      .pinOe    (pinOe[i])
    );
  end
endmodule

// File: rtl/alepsen_pin_ctrl.sv
module alepsen_pin_ctrl
  import alepsen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [7:0]  wrData,
  input  logic        cycleLast,
  input  logic        extNext,
  input  logic        aleWave,
  input  logic        psenWave,
  input  logic        p4Latch5,
  input  logic        p4Latch6,
  output logic        aleOut,
  output logic        aleOe,
  output logic        psenOut,
  output logic        psenOe,
  output logic        p0PullUp,
  output logic [3:0]  p3HighDrive
);
  pinCtrl_t            ctrlStb;
  logic [NUM_PINS-1:0] pinOut, pinOe;

  alepsen_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .wrData      (wrData),
    .cycleLast   (cycleLast),
    .extNext     (extNext),
    .ctrlStb     (ctrlStb),
    .p0PullUp    (p0PullUp),
    .p3HighDrive (p3HighDrive)
  );

  alepsen_dpath u_dpath (
    .ctrlStb   (ctrlStb),
    .wave      ({psenWave, aleWave}),
    .latchBits ({p4Latch6, p4Latch5}),
    .pinOut    (pinOut),
    .pinOe     (pinOe)
  );

  assign aleOut  = pinOut[PIN_ALE];
  assign aleOe   = pinOe[PIN_ALE];
  assign psenOut = pinOut[PIN_PSEN];
  assign psenOe  = pinOe[PIN_PSEN];
endmodule

// File: rtl/alepsen_chk.sv
module alepsen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cycleLast,
  input logic       aleWave,
  input logic       psenWave,
  input logic       p4Latch5,
  input logic       p4Latch6,
  input logic       aleOut,
  input logic       aleOe,
  input logic       psenOut,
  input logic       psenOe,
  input logic       p0PullUp,
  input logic [3:0] p3HighDrive,
  input logic [1:0] portMode,
  input logic [1:0] suppress
);
  a_r2_ale_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!portMode[0] && !suppress[0]) |-> (aleOut == aleWave && aleOe));

  a_r3_ale_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!portMode[0] && suppress[0]) |-> (aleOut && aleOe));

  a_r5_psen_port: assert property (@(posedge clk) disable iff (!rst_n)
    portMode[1] |-> (psenOut == p4Latch6 && psenOe == !p4Latch6));

  a_r5_ale_port: assert property (@(posedge clk) disable iff (!rst_n)
    portMode[0] |-> (aleOut == p4Latch5 && aleOe == !p4Latch5));

  a_r6_psen_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (!portMode[1] && suppress[1]) |-> (psenOut && psenOe));

  a_r6_psen_external: assert property (@(posedge clk) disable iff (!rst_n)
    (!portMode[1] && !suppress[1]) |-> (psenOut == psenWave));

  a_r9_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cycleLast) |-> ($stable(p3HighDrive) && $stable(p0PullUp) && $stable(portMode)));
endmodule

bind alepsen_pin_ctrl alepsen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cycleLast   (cycleLast),
  .aleWave     (aleWave),
  .psenWave    (psenWave),
  .p4Latch5    (p4Latch5),
  .p4Latch6    (p4Latch6),
  .aleOut      (aleOut),
  .aleOe       (aleOe),
  .psenOut     (psenOut),
  .psenOe      (psenOe),
  .p0PullUp    (p0PullUp),
  .p3HighDrive (p3HighDrive),
  .portMode    (ctrlStb.portMode),
  .suppress    (ctrlStb.suppress)
);

// File: tb/alepsen_pin_ctrl_tb.sv
module alepsen_pin_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0, wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic       cycleLast = 1'b0, extNext = 1'b0;
  logic       aleWave = 1'b0, psenWave = 1'b1;
  logic       p4Latch5 = 1'b0, p4Latch6 = 1'b0;
  logic       aleOut, aleOe, psenOut, psenOe, p0PullUp;
  logic [3:0] p3HighDrive;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  alepsen_pin_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cycleLast(cycleLast), .extNext(extNext), .aleWave(aleWave),
    .psenWave(psenWave), .p4Latch5(p4Latch5), .p4Latch6(p4Latch6),
    .aleOut(aleOut), .aleOe(aleOe), .psenOut(psenOut), .psenOe(psenOe),
    .p0PullUp(p0PullUp), .p3HighDrive(p3HighDrive)
  );

  // {opt, aux, ext, aleWave, psenWave, latch5, latch6, aleOut, aleOe, psenOut, psenOe}
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1111}, // R2 R6
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0111}, // R2
    {8'h00, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1111}, // R3
    {8'h00, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101}, // R4 R6
    {8'h00, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1111}, // R4
    {8'hC0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0110}, // R5
    {8'hC0, 8'h01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1001}, // R7
    {8'h40, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0111}, // R7
    {8'h80, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1101}, // R5 R6
    {8'h20, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0111}  // R8
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] data);
    @(negedge clk); wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic boundary(input logic ext);
    @(negedge clk); cycleLast = 1'b1; extNext = ext;
    @(negedge clk); cycleLast = 1'b0;
  endtask

  function automatic logic [3:0] pins();
    return {aleOut, aleOe, psenOut, psenOe};
  endfunction

  initial begin
    #400000;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    aleWave = 1'b1; #1;
    check("R1 pins wave high", {4'b0, pins()}, {4'b0, 4'b1111});
    aleWave = 1'b0; #1;
    check("R1 pins wave low", {4'b0, pins()}, {4'b0, 4'b0111});
    check("R1 pads", {3'b0, p0PullUp, p3HighDrive}, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      writeReg(1'b0, VEC[i][24:17]);
      writeReg(1'b1, VEC[i][16:9]);
      boundary(VEC[i][8]);
      aleWave = VEC[i][7]; psenWave = VEC[i][6];
      p4Latch5 = VEC[i][5]; p4Latch6 = VEC[i][4];
      #1;
      check($sformatf("R2-R7 vector %0d", i), {4'b0, pins()}, {4'b0, VEC[i][3:0]});
    end
    // R8 bit 5 has no pad effect
    check("R8 bit5 no pad effect", {3'b0, p0PullUp, p3HighDrive}, 8'h00);

    // R8 and R9: pad options only after boundary
    writeReg(1'b0, 8'h13);
    check("R9 pads before boundary", {3'b0, p0PullUp, p3HighDrive}, 8'h00);
    boundary(1'b0);
    check("R8 pads after boundary", {3'b0, p0PullUp, p3HighDrive}, {3'b0, 1'b1, 4'b1001});

    // R9 strobe-off write held until boundary
    aleWave = 1'b0; psenWave = 1'b1;
    writeReg(1'b1, 8'h01);
    @(negedge clk); #1;
    check("R9 strobe-off pending", {7'b0, aleOut}, 8'h00);
    boundary(1'b0); #1;
    check("R3 strobe-off applied", {7'b0, aleOut}, 8'h01);

    // R10 extNext ignored without cycleLast
    @(negedge clk); extNext = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    check("R10 extNext without boundary", {7'b0, aleOut}, 8'h01);
    boundary(1'b1); #1;
    check("R10 extNext at boundary", {7'b0, aleOut}, 8'h00);
    boundary(1'b0); #1;
    check("R4 strobe stops after external cycle", {7'b0, aleOut}, 8'h01);

    // R9 upper aux bits ignored, wrSel maps correctly
    writeReg(1'b1, 8'hFE);
    boundary(1'b0); #1;
    check("R9 aux upper bits ignored", {7'b0, aleOut}, 8'h00);
    check("R9 aux write leaves options", {3'b0, p0PullUp, p3HighDrive}, {3'b0, 1'b1, 4'b1001});

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule